// File: doc/BRIEF.md
# Instruction trace buffer controller

This block steers a stream of 32-bit trace words into a circular on-chip trace RAM. Software programs it through a small word-addressed register port that holds a control word, a read-only status word, the write address and a delay count. While capture runs, every valid trace word goes straight out of a simple RAM write port at the current word address. The address then advances and wraps at the buffer size. A 10-bit wrap counter counts the rollovers, and a sticky flag records an overflow of that counter.

Capture starts on a rising edge of the enable bit. It ends some time after a stop trigger. The trigger can be a software write of the stop bit or one of two gated trigger inputs, one for a program-counter match and one for a processor trigger. After the trigger, a delay counter runs down in units of written words or retired instructions, and capture ends when it reaches zero. When capture ends, the write pointer freezes so that the last address can be read back. The block can also raise a periodic request for a synchronization message, and it drives a processor halt trigger either at the stop trigger or when the stop completes.

Register select on `regAddr`: 0 is control, 1 is status, 2 is address and 3 is delay. Reads are combinational on the selected register.

Top module: `trace_capture_ctrl`

## Requirements
- R1: Capture starts only when a write to control sets bit 0 while the stored enable bit is 0. Writing 1 to bit 0 while it already holds 1 does not restart capture, even after capture has ended. Control reads back bit 0 enable, bit 2 match-trigger enable, bit 4 processor-trigger enable, bit 9 countdown unit, bits 14:12 sync period, bit 16 halt-at-trigger and bit 17 halt-at-completion. Bit 1 always reads 0.
- R2: While capture is active, each cycle with `traceValid` high asserts `memWrEn` in that same cycle, with `memWrData` equal to `traceWord` and `memWrAddr` equal to the current word pointer. The pointer then increments and wraps from 2^ADDR_W-1 to 0.
- R3: Each wrap of the pointer increments the wrap count in address bits 30:21. A wrap taken while the count is 1023 sets it to 0 and sets the sticky flag in address bit 31.
- R4: Writing control with bit 1 set during active capture raises a stop trigger and sets status bit 1. If the delay count is 0 at that point, capture ends at that clock edge (status bit 0 reads 0 in the next cycle). The word presented in the trigger cycle is still written.
- R5: With control bit 9 at 0, each word written after the trigger cycle decrements the delay count. Capture ends at the edge where a count of 1 is consumed, so exactly N more words are written for a delay of N.
- R6: With control bit 9 at 1, each cycle with `instRetired` high after the trigger cycle decrements the delay count instead, and words keep being written until the count runs out.
- R7: Writing the delay register (select 3) outside a countdown only loads the value and starts nothing. During a countdown, the write replaces the remaining count, and writing 0 ends capture at that edge. The delay register reads back the current count.
- R8: `pcMatchTrig` triggers a stop only when control bit 2 is set, and `procTrigIn` only when bit 4 is set. The accepted cause is shown in status bit 2 or status bit 4. Triggers are ignored while capture is inactive or after a trigger has already been taken.
- R9: Writing control bit 0 from 1 to 0 ends capture. It also clears status bits 1, 2 and 4, the completion state and the sticky wrap flag. The pointer and the wrap count keep their values.
- R10: For a sync period field n in 1 to 6, `syncReq` pulses for one cycle after every 2^(9-n)-th word written since capture started. A field of 0 or 7 produces no pulses.
- R11: `haltTrigOut`, also reported in status bit 16, is high while (control bit 16 and a stop trigger has been taken) or (control bit 17 and the stop has completed).
- R12: Status bits 12:8 read ADDR_W+2, which is the buffer size as a power of two in bytes (14 for 4096 words). Status bit 0 shows active capture. After reset, every other register bit reads 0.
- R13: When capture is inactive, the pointer holds its value, and an address register write loads the pointer from bits ADDR_W-1:0 and the wrap count from bits 30:21. During active capture, an address write is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 control, 1 status, 2 address, 3 delay |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Combinational read of the selected register |
| traceValid | input | 1 | Trace word valid |
| traceWord | input | 32 | Trace word |
| instRetired | input | 1 | One instruction retired this cycle |
| pcMatchTrig | input | 1 | Program-counter match stop trigger |
| procTrigIn | input | 1 | Processor stop trigger |
| memWrEn | output | 1 | Trace RAM write enable |
| memWrAddr | output | 12 | Trace RAM word address |
| memWrData | output | 32 | Trace RAM write data |
| syncReq | output | 1 | One-cycle request for a synchronization message |
| haltTrigOut | output | 1 | Processor halt trigger |

## Verification
The assertions assume the register port makes at most one write per cycle, so a delay write and a software stop never land in the same cycle. They also assume the sync period stays at least 8 words, which the field encoding guarantees. The stimulus drives the port one transaction per cycle. In the random phase, it masks control writes to the defined bits and keeps delay values small so that countdowns finish often. Hardware trigger pulses are rare and can coincide with delay writes, which exercises the priority between a trigger and a delay load.

// File: rtl/trc_pkg.sv
package trc_pkg;
  localparam int REG_W  = 32;
  localparam int WRAP_W = 10;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_STAT = 2'd1,
    SEL_ADDR = 2'd2,
    SEL_DLY  = 2'd3
  } regSel_t;

  typedef struct packed {
    logic       capEn;
    logic       ptrLoad;
    logic       satClr;
    logic       syncClr;
    logic [2:0] syncPer;
  } dpStrobe_t;
endpackage

// File: rtl/trc_ctrl.sv
module trc_ctrl
  import trc_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [1:0]       regAddr,
  input  logic [REG_W-1:0] regWrData,
  input  logic             traceValid,
  input  logic             instRetired,
  input  logic             pcMatchTrig,
  input  logic             procTrigIn,
  output dpStrobe_t        dpStb,
  output logic [REG_W-1:0] ctrlWord,
  output logic [REG_W-1:0] statusWord,
  output logic [REG_W-1:0] delayWord,
  output logic             haltTrigOut
);
  localparam logic [4:0] MEM_SZ = 5'(ADDR_W + 2);

  logic ctrlEn, pcmEn, ptiEn, cntUnit, haltAtTrig, haltAtDone;
  logic [2:0] syncPer;
  logic active, triggered, pcCause, ptiCause, counting, stopDone;
  logic [REG_W-1:0] delayCnt;

  logic wrCtrl, wrAddr, wrDelay, enRise, enFall;
  logic wordWr, cntEvt, trigReg, trigPc, trigPt, trigNow;
  logic [REG_W-1:0] delayEff;

  logic unusedCtrlBits;
  assign unusedCtrlBits = ^{regWrData[31:18], regWrData[15], regWrData[11:10],
                            regWrData[8:5], regWrData[3]};

  always_comb begin
    wrCtrl   = regWrEn && (regAddr == SEL_CTRL);
    wrAddr   = regWrEn && (regAddr == SEL_ADDR);
    wrDelay  = regWrEn && (regAddr == SEL_DLY);
    enRise   = wrCtrl && regWrData[0] && !ctrlEn;
    enFall   = wrCtrl && !regWrData[0] && ctrlEn;
    wordWr   = active && traceValid;
    cntEvt   = cntUnit ? instRetired : wordWr;
    trigReg  = wrCtrl && regWrData[1];
    trigPc   = pcmEn && pcMatchTrig;
    trigPt   = ptiEn && procTrigIn;
    trigNow  = active && !triggered && !enFall && (trigReg || trigPc || trigPt);
    delayEff = wrDelay ? regWrData : delayCnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlEn     <= 1'b0;
      pcmEn      <= 1'b0;
      ptiEn      <= 1'b0;
      cntUnit    <= 1'b0;
      haltAtTrig <= 1'b0;
      haltAtDone <= 1'b0;
      syncPer    <= 3'd0;
      active     <= 1'b0;
      triggered  <= 1'b0;
      pcCause    <= 1'b0;
      ptiCause   <= 1'b0;
      counting   <= 1'b0;
      stopDone   <= 1'b0;
      delayCnt   <= '0;
    end else begin
      if (wrCtrl) begin
        ctrlEn     <= regWrData[0];
        pcmEn      <= regWrData[2];
        ptiEn      <= regWrData[4];
        cntUnit    <= regWrData[9];
        syncPer    <= regWrData[14:12];
        haltAtTrig <= regWrData[16];
        haltAtDone <= regWrData[17];
      end
      if (enFall || enRise) begin
        active    <= enRise;
        triggered <= 1'b0;
        pcCause   <= 1'b0;
        ptiCause  <= 1'b0;
        counting  <= 1'b0;
        stopDone  <= 1'b0;
      end else begin
        if (wrDelay) delayCnt <= regWrData;
        if (trigNow) begin
          triggered <= 1'b1;
          pcCause   <= trigPc;
          ptiCause  <= trigPt;
          if (delayEff == '0) begin
            active   <= 1'b0;
            stopDone <= 1'b1;
          end else begin
            counting <= 1'b1;
          end
        end else if (counting) begin
          if (wrDelay) begin
            if (regWrData == '0) begin
              active   <= 1'b0;
              counting <= 1'b0;
              stopDone <= 1'b1;
            end
          end else if (cntEvt) begin
            delayCnt <= delayCnt - REG_W'(1);
            if (delayCnt == REG_W'(1)) begin
              active   <= 1'b0;
              counting <= 1'b0;
              stopDone <= 1'b1;
            end
          end
        end
      end
    end
  end

  always_comb begin
    dpStb.capEn   = active;
    dpStb.ptrLoad = wrAddr && !active;
    dpStb.satClr  = enFall;
    dpStb.syncClr = enRise;
    dpStb.syncPer = syncPer;
  end

  assign haltTrigOut = (haltAtTrig && triggered) || (haltAtDone && stopDone);

  always_comb begin
    ctrlWord        = '0;
    ctrlWord[0]     = ctrlEn;
    ctrlWord[2]     = pcmEn;
    ctrlWord[4]     = ptiEn;
    ctrlWord[9]     = cntUnit;
    ctrlWord[14:12] = syncPer;
    ctrlWord[16]    = haltAtTrig;
    ctrlWord[17]    = haltAtDone;
    statusWord       = '0;
    statusWord[0]    = active;
    statusWord[1]    = triggered;
    statusWord[2]    = pcCause;
    statusWord[4]    = ptiCause;
    statusWord[12:8] = MEM_SZ;
    statusWord[16]   = haltTrigOut;
    delayWord        = delayCnt;
  end

  AST_STOP_ENDS_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stopDone) |-> !active); // R4
  AST_COUNT_WHILE_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    counting |-> (active && triggered)); // R5
  AST_TRIG_FROM_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(triggered) |-> $past(active)); // R8
endmodule

// File: rtl/trc_datapath.sv
module trc_datapath
  import trc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int TW     = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         dpStb,
  input  logic              traceValid,
  input  logic [TW-1:0]     traceWord,
  input  logic [REG_W-1:0]  ldData,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [TW-1:0]     memWrData,
  output logic [WRAP_W-1:0] wrapCnt,
  output logic              wrapSat,
  output logic              syncReq
);
  localparam int SYNC_W = 9;
  localparam logic [ADDR_W-1:0] PTR_MAX  = '1;
  localparam logic [WRAP_W-1:0] WRAP_MAX = '1;

  logic [ADDR_W-1:0] ptr;
  logic [SYNC_W-1:0] syncCnt, syncLast;
  logic              syncOn;
  logic              wordWr;

  logic unusedLdBits;
  assign unusedLdBits = ^{ldData[31], ldData[20:ADDR_W]};

  assign wordWr    = dpStb.capEn && traceValid;
  assign memWrEn   = wordWr;
  assign memWrAddr = ptr;
  assign memWrData = traceWord;

  always_comb begin
    syncOn   = (dpStb.syncPer != 3'd0) && (dpStb.syncPer != 3'd7);
    syncLast = syncOn ? ((SYNC_W'(1) << (4'd9 - {1'b0, dpStb.syncPer})) - SYNC_W'(1))
                      : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr     <= '0;
      wrapCnt <= '0;
      wrapSat <= 1'b0;
    end else begin
      if (wordWr) begin
        ptr <= ptr + ADDR_W'(1);
        if (ptr == PTR_MAX) begin
          wrapCnt <= wrapCnt + WRAP_W'(1);
          if (wrapCnt == WRAP_MAX) wrapSat <= 1'b1;
        end
      end else if (dpStb.ptrLoad) begin
        ptr     <= ldData[ADDR_W-1:0];
        wrapCnt <= ldData[30:21];
      end
      if (dpStb.satClr) wrapSat <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncCnt <= '0;
      syncReq <= 1'b0;
    end else begin
      syncReq <= 1'b0;
      if (dpStb.syncClr) begin
        syncCnt <= '0;
      end else if (wordWr) begin
        if (!syncOn) begin
          syncCnt <= '0;
        end else if (syncCnt >= syncLast) begin
          syncCnt <= '0;
          syncReq <= 1'b1;
        end else begin
          syncCnt <= syncCnt + SYNC_W'(1);
        end
      end
    end
  end

  AST_PTR_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (!dpStb.capEn && !dpStb.ptrLoad) |=> $stable(ptr)); // R13
  AST_SAT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (wrapSat && !dpStb.satClr) |=> wrapSat); // R3
  AST_SYNC_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    syncReq |=> !syncReq); // R10
  AST_SYNC_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(syncReq) |-> $past(memWrEn)); // R10
endmodule

// File: rtl/trace_capture_ctrl.sv
module trace_capture_ctrl
  import trc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int TW     = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              traceValid,
  input  logic [TW-1:0]     traceWord,
  input  logic              instRetired,
  input  logic              pcMatchTrig,
  input  logic              procTrigIn,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [TW-1:0]     memWrData,
  output logic              syncReq,
  output logic              haltTrigOut
);
  localparam int PAD_W = 21 - ADDR_W;

  dpStrobe_t         dpStb;
  logic [REG_W-1:0]  ctrlWord, statusWord, delayWord;
  logic [WRAP_W-1:0] wrapCnt;
  logic              wrapSat;

  trc_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .traceValid(traceValid), .instRetired(instRetired),
    .pcMatchTrig(pcMatchTrig), .procTrigIn(procTrigIn), .dpStb(dpStb),
    .ctrlWord(ctrlWord), .statusWord(statusWord), .delayWord(delayWord),
    .haltTrigOut(haltTrigOut)
  );

  trc_datapath #(.ADDR_W(ADDR_W), .TW(TW)) uDp (
    .clk(clk), .rstN(rstN), .dpStb(dpStb), .traceValid(traceValid),
    .traceWord(traceWord), .ldData(regWrData), .memWrEn(memWrEn),
    .memWrAddr(memWrAddr), .memWrData(memWrData), .wrapCnt(wrapCnt),
    .wrapSat(wrapSat), .syncReq(syncReq)
  );

  always_comb begin
    unique case (regAddr)
      SEL_CTRL: regRdData = ctrlWord;
      SEL_STAT: regRdData = statusWord;
      SEL_ADDR: regRdData = {wrapSat, wrapCnt, {PAD_W{1'b0}}, memWrAddr};
      default:  regRdData = delayWord;
    endcase
  end
endmodule

// File: tb/sim_trace_capture_ctrl.sv
`timescale 1ns/1ps
module sim_trace_capture_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn, instRetired, pcMatchTrig, procTrigIn, traceValid;
  logic [1:0] regAddr;
  logic [31:0] regWrData, traceWord, regRdData, memWrData;
  logic memWrEn, syncReq, haltTrigOut;
  logic [11:0] memWrAddr;

  always #10 clk = ~clk;

  trace_capture_ctrl u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .traceValid(traceValid),
    .traceWord(traceWord), .instRetired(instRetired), .pcMatchTrig(pcMatchTrig),
    .procTrigIn(procTrigIn), .memWrEn(memWrEn), .memWrAddr(memWrAddr),
    .memWrData(memWrData), .syncReq(syncReq), .haltTrigOut(haltTrigOut)
  );

  int nChecks = 0;
  int nFail = 0;
  string curTag = "R12";

  // expected state, built from the requirements
  logic mEn, mPcm, mPti, mCnt, mHt, mHd;
  logic [2:0] mSm;
  logic mAct, mTrig, mPcC, mPtC, mCounting, mDone;
  logic [31:0] mDelay;
  logic [11:0] mPtr;
  logic [9:0] mWrap;
  logic mSat, mSyncReq;
  int mSyncCnt;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int syncPeriod(logic [2:0] n);
    return (n >= 3'd1 && n <= 3'd6) ? (1 << (9 - int'(n))) : 0;
  endfunction

  function automatic logic mHalt();
    return (mHt && mTrig) || (mHd && mDone);
  endfunction

  function automatic logic [31:0] expRead(logic [1:0] a);
    logic [31:0] v = '0;
    case (a)
      2'd0: begin
        v[0] = mEn; v[2] = mPcm; v[4] = mPti; v[9] = mCnt;
        v[14:12] = mSm; v[16] = mHt; v[17] = mHd;
      end
      2'd1: begin
        v[0] = mAct; v[1] = mTrig; v[2] = mPcC; v[4] = mPtC;
        v[12:8] = 5'd14; v[16] = mHalt();
      end
      2'd2: v = {mSat, mWrap, 9'd0, mPtr};
      default: v = mDelay;
    endcase
    return v;
  endfunction

  task automatic modelReset();
    {mEn, mPcm, mPti, mCnt, mHt, mHd} = '0;
    mSm = '0;
    {mAct, mTrig, mPcC, mPtC, mCounting, mDone} = '0;
    mDelay = '0; mPtr = '0; mWrap = '0; mSat = 1'b0; mSyncReq = 1'b0; mSyncCnt = 0;
  endtask

  task automatic modelAdvance();
    logic wrC, wrA, wrD, rise, fall, ww, evt, tR, tPc, tPt, tNow, ldA;
    logic [31:0] dEff;
    int p;
    wrC  = regWrEn && regAddr == 2'd0;
    wrA  = regWrEn && regAddr == 2'd2;
    wrD  = regWrEn && regAddr == 2'd3;
    rise = wrC && regWrData[0] && !mEn;
    fall = wrC && !regWrData[0] && mEn;
    ww   = mAct && traceValid;
    evt  = mCnt ? instRetired : ww;
    tR   = wrC && regWrData[1];
    tPc  = mPcm && pcMatchTrig;
    tPt  = mPti && procTrigIn;
    tNow = mAct && !mTrig && !fall && (tR || tPc || tPt);
    dEff = wrD ? regWrData : mDelay;
    ldA  = wrA && !mAct;
    p    = syncPeriod(mSm);
    mSyncReq = 1'b0;
    if (rise) mSyncCnt = 0;
    else if (ww) begin
      if (p == 0) mSyncCnt = 0;
      else if (mSyncCnt >= p - 1) begin mSyncCnt = 0; mSyncReq = 1'b1; end
      else mSyncCnt++;
    end
    if (ww) begin
      if (mPtr == 12'hFFF) begin
        if (mWrap == 10'h3FF) mSat = 1'b1;
        mWrap = mWrap + 10'd1;
      end
      mPtr = mPtr + 12'd1;
    end else if (ldA) begin
      mPtr = regWrData[11:0]; mWrap = regWrData[30:21];
    end
    if (fall) mSat = 1'b0;
    if (fall || rise) begin
      mAct = rise; mTrig = 0; mPcC = 0; mPtC = 0; mCounting = 0; mDone = 0;
    end else begin
      if (wrD) mDelay = regWrData;
      if (tNow) begin
        mTrig = 1; mPcC = tPc; mPtC = tPt;
        if (dEff == 0) begin mAct = 0; mDone = 1; end
        else mCounting = 1;
      end else if (mCounting) begin
        if (wrD) begin
          if (regWrData == 0) begin mAct = 0; mCounting = 0; mDone = 1; end
        end else if (evt) begin
          if (mDelay == 1) begin mAct = 0; mCounting = 0; mDone = 1; end
          mDelay = mDelay - 1;
        end
      end
    end
    if (wrC) begin
      mEn = regWrData[0]; mPcm = regWrData[2]; mPti = regWrData[4];
      mCnt = regWrData[9]; mSm = regWrData[14:12];
      mHt = regWrData[16]; mHd = regWrData[17];
    end
  endtask

  // inputs are already set at the falling edge; check, advance the model, wait
  task automatic step();
    #1;
    chk("R2 write enable", {31'd0, memWrEn}, {31'd0, mAct && traceValid});
    if (mAct && traceValid) begin
      chk("R2 write address", {20'd0, memWrAddr}, {20'd0, mPtr});
      chk("R2 write data", memWrData, traceWord);
    end
    chk("R10 sync request", {31'd0, syncReq}, {31'd0, mSyncReq});
    chk("R11 halt output", {31'd0, haltTrigOut}, {31'd0, mHalt()});
    if (!regWrEn) chk({curTag, " register read"}, regRdData, expRead(regAddr));
    modelAdvance();
    @(negedge clk);
  endtask

  task automatic setIdle();
    regWrEn = 0; regAddr = 2'd1; regWrData = '0; traceValid = 0;
    traceWord = '0; instRetired = 0; pcMatchTrig = 0; procTrigIn = 0;
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    regWrEn = 1; regAddr = a; regWrData = d;
    step();
    regWrEn = 0; regWrData = '0;
  endtask

  task automatic rd(logic [1:0] a, int n);
    regAddr = a;
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic words(int n, logic inst);
    for (int i = 0; i < n; i++) begin
      traceValid = 1; traceWord = $urandom; instRetired = inst;
      regAddr = 2'(i % 4);
      step();
    end
    traceValid = 0; instRetired = 0;
  endtask

  task automatic restart(logic [31:0] ctl);
    wr(2'd0, 32'd0);
    wr(2'd0, ctl | 32'd1);
  endtask

  initial begin
    #(20ns * 150000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    setIdle();
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1;
    // R12 reset state and size field
    curTag = "R12";
    rd(2'd1, 1); rd(2'd2, 1); rd(2'd0, 1); rd(2'd3, 1);
    // R1 rising edge starts, repeated 1 does not restart
    curTag = "R1";
    wr(2'd0, 32'h1);
    words(5, 0);
    wr(2'd0, 32'h1);
    words(3, 0); rd(2'd2, 1); rd(2'd0, 1);
    // R7 idle delay load while no countdown, R4 immediate stop
    curTag = "R7";
    wr(2'd3, 32'd0); rd(2'd1, 2);
    curTag = "R4";
    traceValid = 1; wr(2'd0, 32'h3); traceValid = 0;
    rd(2'd1, 1); words(3, 0); rd(2'd2, 1);
    curTag = "R1";
    wr(2'd0, 32'h1); words(2, 0); rd(2'd1, 1);
    // R9 disable clears status
    curTag = "R9";
    wr(2'd0, 32'h0); rd(2'd1, 1);
    // R5 word countdown with completion halt
    curTag = "R5";
    wr(2'd3, 32'd3);
    wr(2'd0, 32'h2_0001);
    words(4, 0);
    wr(2'd0, 32'h2_0003);
    rd(2'd1, 2); words(1, 0); rd(2'd3, 2); words(4, 0);
    curTag = "R11"; rd(2'd1, 2);
    curTag = "R13"; rd(2'd2, 2); words(3, 0); rd(2'd2, 1);
    // R6 instruction countdown with trigger-time halt
    curTag = "R6";
    restart(32'h1_0200);
    wr(2'd3, 32'd2);
    wr(2'd0, 32'h1_0203);
    words(3, 0); rd(2'd1, 1);
    instRetired = 1; rd(2'd1, 1); instRetired = 0;
    words(2, 0);
    words(2, 1); rd(2'd1, 2);
    // R7 delay replaced during countdown, then zero write stops
    curTag = "R7";
    restart(32'h0);
    wr(2'd3, 32'd5);
    wr(2'd0, 32'h3);
    words(2, 0);
    wr(2'd3, 32'd4); rd(2'd3, 1);
    words(3, 0); rd(2'd1, 1);
    wr(2'd3, 32'd0); rd(2'd1, 2);
    // R8 gated input triggers
    curTag = "R8";
    restart(32'h0);
    wr(2'd3, 32'd0);
    pcMatchTrig = 1; procTrigIn = 1; rd(2'd1, 2);
    pcMatchTrig = 0; procTrigIn = 0;
    wr(2'd0, 32'h5);
    pcMatchTrig = 1; rd(2'd1, 1); pcMatchTrig = 0; rd(2'd1, 2);
    procTrigIn = 1; rd(2'd1, 1); procTrigIn = 0;
    restart(32'h10);
    wr(2'd3, 32'd2);
    procTrigIn = 1; pcMatchTrig = 1; rd(2'd1, 1);
    procTrigIn = 0; pcMatchTrig = 0;
    words(2, 0); rd(2'd1, 2);
    // R3 wrap counter saturation, R13 address write blocked while active
    curTag = "R3";
    wr(2'd0, 32'h0);
    wr(2'd2, {1'b0, 10'h3FF, 9'd0, 12'hFFE});
    rd(2'd2, 1);
    wr(2'd0, 32'h1);
    words(2, 0); rd(2'd2, 2);
    curTag = "R13";
    wr(2'd2, 32'h0000_0123); rd(2'd2, 1);
    curTag = "R9";
    wr(2'd0, 32'h0); rd(2'd2, 1); rd(2'd1, 1);
    // R10 sync periods
    curTag = "R10";
    restart(32'h6000); words(20, 0);
    restart(32'h1000); words(300, 0);
    restart(32'h7000); words(40, 0);
    restart(32'h0000); words(20, 0);
    // random mix
    curTag = "R2";
    for (int i = 0; i < 4000; i++) begin
      int r;
      setIdle();
      traceValid = $urandom_range(0, 1);
      traceWord = $urandom;
      instRetired = $urandom_range(0, 1);
      pcMatchTrig = ($urandom_range(0, 49) == 0);
      procTrigIn = ($urandom_range(0, 49) == 0);
      regAddr = 2'($urandom_range(0, 3));
      r = $urandom_range(0, 99);
      if (r < 3) begin regWrEn = 1; regAddr = 2'd0; regWrData = $urandom & 32'h0003_7217; end
      else if (r < 6) begin regWrEn = 1; regAddr = 2'd3; regWrData = $urandom_range(0, 11); end
      else if (r < 7) begin regWrEn = 1; regAddr = 2'd2; regWrData = $urandom; end
      else if (r < 9 && !mEn) begin regWrEn = 1; regAddr = 2'd0; regWrData = 32'h1 | ($urandom & 32'h0003_7214); end
      step();
    end
    setIdle();
    rd(2'd1, 2);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule